// File: doc/BRIEF.md
# Constant-Divisor Unsigned Quotient Unit

This unit returns the quotient of a 32-bit unsigned index divided by a divisor that stays fixed for a run. The divisor is not given directly. Software prepares it once as a small set of constants, and each transfer carries those constants with the index. A power-of-two divisor uses a plain right shift. Any other divisor uses a multiply by a scaled reciprocal, keeps the upper product word, optionally applies a round-down correction, and then shifts right. The multiplier always behaves as if its most significant bit were set, so only its low 31 bits carry information. The dividend is never shifted before the multiply.

The constants for a divisor d are prepared as follows:
- sh = floor(log2 d)
- r = 2^(sh+32) mod d
- c = ceil(2^(sh+32) / d)
- If r does not exceed 2^sh, the stored multiplier is c − 1 and the round-down flag is 1.
- Otherwise the stored multiplier is c and the flag is 0.

The datapath has two registered stages: the multiply, then the shift. Each side has a valid/ready handshake, so downstream back-pressure stalls the pipe without dropping or repeating a result.

Top module: `magdiv_top`

## Requirements
- R1: With `in_pow2` = 1, the quotient equals `in_index` shifted right by `in_shift`, and the multiplier and flag have no effect.
- R2: With `in_pow2` = 0 and `in_round` = 0, the quotient is floor(M·index / 2^32) >> `in_shift`, where M is the effective multiplier.
- R3: The effective multiplier M is `in_mult` with bit 31 forced to 1, so two multipliers that differ only in bit 31 give the same quotient.
- R4: With `in_pow2` = 0 and `in_round` = 1, the quotient is floor(M·(index+1) / 2^32) >> `in_shift`, computed without wrap, so index 0xFFFFFFFF uses 2^32.
- R5: With constants prepared by the recipe above, the quotient equals floor(index / d) for every 32-bit index, and for d = 1 or any power of two when power-of-two mode is used.
- R6: With `out_ready` held high, a transfer accepted at one rising edge raises `out_valid` after the following rising edge, and `out_valid` is low between those two edges.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid` stays 1 and `out_quot` holds its value at the next edge.
- R8: `in_ready` is 1 whenever `out_valid` = 0. It is 0 when both stages hold a result and the output is stalled.
- R9: During and right after synchronous reset, `out_valid` = 0 and `in_ready` = 1.
- R10: Results leave in acceptance order, each exactly once, under any pattern of input gaps and output stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request carries a valid operand set |
| in_ready | output | 1 | Unit accepts the request at this edge |
| in_index | input | DIV_W | Dividend |
| in_mult | input | DIV_W | Stored multiplier; top bit is treated as 1 |
| in_shift | input | SHIFT_W | Final right-shift amount |
| in_round | input | 1 | 1 selects the round-down correction |
| in_pow2 | input | 1 | 1 selects shift-only mode |
| out_valid | output | 1 | Quotient is available |
| out_ready | input | 1 | Consumer takes the quotient at this edge |
| out_quot | output | DIV_W | Quotient |

## Verification
The case of interest is a cycle in which the multiply stage accepts a new index while the shift stage is either handing a quotient downstream or holding one under a stall. This exercises the ready chain, and a fault there loses or duplicates a result. The bench provokes this cycle by streaming back-to-back requests with the consumer always ready, and then again with random input gaps and random `out_ready` drops. Every delivered value is compared, in order, with true integer division or with the arithmetic formula of its mode. Each stalled cycle is also checked to confirm that the held quotient did not change.

// File: rtl/magdiv_pkg.sv
package magdiv_pkg;

    typedef enum logic {
        DM_MAGIC = 1'b0,
        DM_POW2  = 1'b1
    } div_mode_e;

    function automatic div_mode_e mode_of(input logic pow2_sel);
        return pow2_sel ? DM_POW2 : DM_MAGIC;
    endfunction

endpackage

// File: rtl/magdiv_mul_stage.sv
module magdiv_mul_stage #(
    parameter int W = 32
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] mult,
    input  logic         round_dn,
    output logic [W-1:0] hi_word
);
    localparam int OPW  = W + 1;
    localparam int PRDW = 2 * W + 1;

    logic [W-1:0]    eff_mult;
    logic [OPW-1:0]  operand;
    logic [PRDW-1:0] product;
    logic [PRDW-1:0] shifted;

    always_comb begin
        eff_mult = mult | (W'(1) << (W - 1));
        operand  = {1'b0, idx} + OPW'(round_dn);
        product  = {{(PRDW - W){1'b0}}, eff_mult} * {{(PRDW - OPW){1'b0}}, operand};
        shifted  = product >> W;
        hi_word  = W'(shifted);
    end
endmodule

// File: rtl/magdiv_slot.sv
module magdiv_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [DW-1:0] up_data,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [DW-1:0] dn_data
);
    logic          full_q;
    logic [DW-1:0] data_q;

    assign up_ready = !full_q || dn_ready;
    assign dn_valid = full_q;
    assign dn_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (up_ready) begin
            full_q <= up_valid;
            if (up_valid) begin
                data_q <= up_data;
            end
        end
    end
endmodule

// File: rtl/magdiv_top.sv
module magdiv_top
    import magdiv_pkg::*;
#(
    parameter int DIV_W   = 32,
    parameter int SHIFT_W = $clog2(DIV_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DIV_W-1:0]   in_index,
    input  logic [DIV_W-1:0]   in_mult,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic               in_round,
    input  logic               in_pow2,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DIV_W-1:0]   out_quot
);
    localparam int S1W = DIV_W + SHIFT_W;

    typedef struct packed {
        logic [SHIFT_W-1:0] sh;
        logic [DIV_W-1:0]   word;
    } s1_pkt_t;

    logic [DIV_W-1:0] hi_word;
    s1_pkt_t          s1_in;
    s1_pkt_t          s1_pkt;
    logic [S1W-1:0]   s1_bits;
    logic             s1_vld;
    logic             s2_rdy;
    logic [DIV_W-1:0] s2_in;

    magdiv_mul_stage #(.W(DIV_W)) u_mul (
        .idx      (in_index),
        .mult     (in_mult),
        .round_dn (in_round),
        .hi_word  (hi_word)
    );

    always_comb begin
        s1_in.sh   = in_shift;
        s1_in.word = (mode_of(in_pow2) == DM_POW2) ? in_index : hi_word;
    end

    magdiv_slot #(.DW(S1W)) u_slot_mul (
        .clk      (clk),
        .rst      (rst),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (s1_in),
        .dn_valid (s1_vld),
        .dn_ready (s2_rdy),
        .dn_data  (s1_bits)
    );

    assign s1_pkt = s1_pkt_t'(s1_bits);
    assign s2_in  = s1_pkt.word >> s1_pkt.sh;

    magdiv_slot #(.DW(DIV_W)) u_slot_shf (
        .clk      (clk),
        .rst      (rst),
        .up_valid (s1_vld),
        .up_ready (s2_rdy),
        .up_data  (s2_in),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (out_quot)
    );
endmodule

// File: rtl/magdiv_top_chk.sv
module magdiv_top_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_quot,
    input logic         s1_vld
);
    // R9
    rst_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R7
    hold_quot_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_quot));

    // R8
    free_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    // R8
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        s1_vld && out_valid && !out_ready |-> !in_ready);

    // R10
    keep_s1_chk: assert property (@(posedge clk) disable iff (rst)
        s1_vld && out_valid && !out_ready |=> s1_vld);

    // R6
    take_in_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> s1_vld);
endmodule

bind magdiv_top magdiv_top_chk #(.W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_quot  (out_quot),
    .s1_vld    (s1_vld)
);

// File: tb/magdiv_top_bench.sv
`timescale 1ns/100ps
module magdiv_top_bench;
    localparam int W  = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_index = '0;
    logic [W-1:0]  in_mult = '0;
    logic [SW-1:0] in_shift = '0;
    logic          in_round = 1'b0;
    logic          in_pow2 = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [W-1:0]  out_quot;

    always #2 clk = ~clk;

    magdiv_top u_magdiv_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_index(in_index), .in_mult(in_mult), .in_shift(in_shift),
        .in_round(in_round), .in_pow2(in_pow2), .out_valid(out_valid),
        .out_ready(out_ready), .out_quot(out_quot)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_push = 0;
    int n_got = 0;
    int rdy_pct = 100;
    int vld_pct = 100;
    logic prev_stall = 1'b0;
    logic [W-1:0] prev_q = '0;

    logic [W-1:0]  p_idx[$];
    logic [W-1:0]  p_m[$];
    logic [SW-1:0] p_sh[$];
    logic          p_rd[$];
    logic          p_p2[$];
    logic [W-1:0]  p_exp[$];
    string         p_tag[$];
    logic [W-1:0]  o_exp[$];
    string         o_tag[$];

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] raw_q(input logic [W-1:0] idx, input logic [W-1:0] m,
                                           input logic [SW-1:0] sh, input logic rd);
        longint unsigned eff = {32'd0, m | 32'h8000_0000};
        longint unsigned op  = {32'd0, idx} + (rd ? 64'd1 : 64'd0);
        longint unsigned pr  = eff * op;
        return 32'((pr >> 32) >> sh);
    endfunction

    task automatic push(input logic [W-1:0] idx, input logic [W-1:0] m, input logic [SW-1:0] sh,
                        input logic rd, input logic p2, input logic [W-1:0] exp, input string tag);
        p_idx.push_back(idx); p_m.push_back(m); p_sh.push_back(sh);
        p_rd.push_back(rd); p_p2.push_back(p2); p_exp.push_back(exp); p_tag.push_back(tag);
        n_push++;
    endtask

    task automatic push_div(input longint unsigned d, input logic [W-1:0] idx, input logic clr31);
        int s = 0;
        longint unsigned pw, mm, e;
        while ((d >> (s + 1)) != 0) s++;
        if ((d & (d - 1)) == 0) begin
            push(idx, 32'h1234_5678, SW'(s), 1'b1, 1'b1, 32'(64'(idx) / d), "R5");
        end else begin
            pw = 64'd1 << (s + 32);
            mm = (pw + d - 1) / d;
            e  = pw % d;
            if (e <= (64'd1 << s)) mm = mm - 1;
            push(idx, 32'(mm) & (clr31 ? 32'h7FFF_FFFF : 32'hFFFF_FFFF), SW'(s),
                 (e <= (64'd1 << s)), 1'b0, 32'(64'(idx) / d), "R5");
        end
    endtask

    task automatic step();
        @(negedge clk);
        out_ready = (($urandom % 100) < rdy_pct);
        if (p_idx.size() > 0 && (($urandom % 100) < vld_pct)) begin
            in_valid = 1'b1;
            in_index = p_idx[0]; in_mult = p_m[0]; in_shift = p_sh[0];
            in_round = p_rd[0];  in_pow2 = p_p2[0];
        end else begin
            in_valid = 1'b0;
        end
        #1;
        if (prev_stall) begin
            check("R7 valid held", {31'd0, out_valid}, 32'd1);
            check("R7 value held", out_quot, prev_q);
        end
        if (!out_valid) check("R8 ready when empty", {31'd0, in_ready}, 32'd1);
        if (in_valid && in_ready) begin
            o_exp.push_back(p_exp[0]); o_tag.push_back(p_tag[0]);
            void'(p_idx.pop_front()); void'(p_m.pop_front()); void'(p_sh.pop_front());
            void'(p_rd.pop_front()); void'(p_p2.pop_front()); void'(p_exp.pop_front());
            void'(p_tag.pop_front());
        end
        if (out_valid && out_ready) begin
            if (o_exp.size() == 0) begin
                check("R10 unexpected result", out_quot, 32'hDEAD_BEEF);
            end else begin
                check(o_tag[0], out_quot, o_exp[0]);
                void'(o_exp.pop_front()); void'(o_tag.pop_front());
                n_got++;
            end
        end
        prev_stall = out_valid && !out_ready;
        prev_q     = out_quot;
    endtask

    task automatic drain();
        int guard = 0;
        while ((p_idx.size() > 0 || o_exp.size() > 0) && guard < 50000) begin
            step();
            guard++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        prev_stall = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        longint unsigned divs [16] = '{64'd1, 64'd2, 64'd3, 64'd5, 64'd7, 64'd9, 64'd10, 64'd72,
                                       64'd641, 64'd1000, 64'd65536, 64'd1000003,
                                       64'd2147483647, 64'h8000_0000, 64'd4294967291,
                                       64'hFFFF_FFFF};
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R9 in_ready in reset", {31'd0, in_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R9 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R9 in_ready after reset", {31'd0, in_ready}, 32'd1);

        // R6: latency with consumer always ready
        in_valid = 1'b1; in_index = 32'd100; in_shift = 5'd2; in_pow2 = 1'b1;
        in_mult = 32'hFFFF_FFFF; in_round = 1'b1;
        @(negedge clk); in_valid = 1'b0; #1;
        check("R6 not yet valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk); #1;
        check("R6 valid after second edge", {31'd0, out_valid}, 32'd1);
        check("R1 pow2 ignores mult and flag", out_quot, 32'd25);
        @(negedge clk); #1;

        // R1: shift-only mode across every shift amount
        for (int s = 0; s < 32; s++) begin
            push(32'hFFFF_FFFF, 32'h0, SW'(s), 1'b0, 1'b1, 32'hFFFF_FFFF >> s, "R1");
            push(32'h9ABC_DEF1, 32'h5555_5555, SW'(s), 1'b1, 1'b1, 32'h9ABC_DEF1 >> s, "R1");
        end
        // R2 and R3: formula checks, flag clear, top multiplier bit set or clear
        for (int k = 0; k < 24; k++) begin
            logic [W-1:0] ix = $urandom;
            logic [W-1:0] mm = $urandom;
            logic [SW-1:0] sh = SW'($urandom % 32);
            push(ix, mm | 32'h8000_0000, sh, 1'b0, 1'b0, raw_q(ix, mm, sh, 1'b0), "R2");
            push(ix, mm & 32'h7FFF_FFFF, sh, 1'b0, 1'b0, raw_q(ix, mm, sh, 1'b0), "R3");
        end
        // R4: round-down formula including the all-ones index
        push(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R4");
        push(32'hFFFF_FFFF, 32'h0, 5'd0, 1'b1, 1'b0, 32'h8000_0000, "R4");
        push(32'hFFFF_FFFF, 32'h2AAA_AAAA, 5'd1, 1'b1, 1'b0, 32'd1431655765, "R4");
        for (int k = 0; k < 16; k++) begin
            logic [W-1:0] ix = $urandom;
            logic [W-1:0] mm = $urandom;
            push(ix, mm, SW'(k), 1'b1, 1'b0, raw_q(ix, mm, SW'(k), 1'b1), "R4");
        end
        rdy_pct = 100; vld_pct = 100;
        drain();

        // R5: true division, back-to-back then with gaps and stalls (R10)
        for (int pass = 0; pass < 2; pass++) begin
            rdy_pct = (pass == 0) ? 100 : 55;
            vld_pct = (pass == 0) ? 100 : 70;
            for (int i = 0; i < 16; i++) begin
                longint unsigned d = divs[i];
                logic c31 = logic'(i % 2);
                push_div(d, 32'd0, c31);
                push_div(d, 32'd1, c31);
                push_div(d, 32'(d - 1), c31);
                push_div(d, 32'(d), c31);
                push_div(d, 32'(d + 1), c31);
                push_div(d, 32'hFFFF_FFFE, c31);
                push_div(d, 32'hFFFF_FFFF, c31);
                for (int r = 0; r < 12; r++) push_div(d, $urandom, c31);
            end
            drain();
        end

        // R10: every accepted request produced exactly one result
        check("R10 results delivered", 32'(n_got), 32'(n_push));
        check("R10 nothing pending", 32'(o_exp.size() + p_idx.size()), 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule